// File: doc/BRIEF.md
# Stereo Output Router with Zero-Run Automute

This block sits between a serial audio receiver and the output converters. Each sample period it receives one signed left/right pair with a valid strobe. It then produces a registered left and right output pair. A 4-bit routing code picks, for each output channel on its own, one of four sources: silence, the left input, the right input, or the average of the two. With this code the same hardware can act as a normal stereo path, a channel swap, a mono downmix, or a full mute.

A run-length counter watches the incoming pairs. When a long unbroken run of all-zero pairs has been seen and automute is armed, the block raises an automute flag and forces both outputs to zero. Automute is armed when the zero-detect enable bit or the external mute pin is high. It is fully disabled only when both are low. The first pair that is nonzero on either channel ends the run at once.

Top module: `stereo_router_automute`

## Requirements
- R1: While `rst_n` is low, `out_vld`, `out_left`, `out_right` and `automute_active` are all zero.
- R2: A pair presented with `in_vld` high appears on the outputs at the next rising clock edge, and `out_vld` is high for exactly that one cycle. Cycles with `in_vld` low change neither the outputs nor the zero-run count.
- R3: `route_code[3:2]` selects the left output source and `route_code[1:0]` selects the right output source, using 2'b00 = zero, 2'b01 = right input, 2'b10 = left input, 2'b11 = average.
- R4: Code 4'b1001 passes left to left and right to right. Code 4'b0110 swaps the channels. Code 4'b1111 drives the average on both outputs. Code 4'b0000 drives zero on both outputs.
- R5: The average is floor((L+R)/2), computed on the full signed sum with one extra bit, so it never overflows (e.g. 32767 and 32767 give 32767; -1 and 0 give -1).
- R6: When automute is armed, the pair that completes 1024 consecutive all-zero valid pairs, and every later zero pair in the same run, sets `automute_active` and forces both outputs to zero. The 1023rd pair does not.
- R7: A valid pair with a nonzero value on either channel clears the run, and `automute_active` is low for that same pair.
- R8: Automute is armed when `zdet_en` or `mute_pin` is high. With both low, `automute_active` never rises.
- R9: The run count saturates at 1024 and does not wrap, so a zero run of any length beyond 1024 stays muted. Idle cycles without `in_vld` do not break the run.
- R10: The run is counted whether or not automute is armed. If automute is armed after 1024 or more zeros have already been seen, the next zero pair mutes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input pair valid strobe |
| in_left | input | 16 | Left input sample, signed |
| in_right | input | 16 | Right input sample, signed |
| route_code | input | 4 | Per-channel source select, left in [3:2], right in [1:0] |
| zdet_en | input | 1 | Zero-detect automute enable (low after reset by the control logic) |
| mute_pin | input | 1 | External mute pin, also arms automute |
| out_vld | output | 1 | Output pair updated this cycle |
| out_left | output | 16 | Left output sample, signed |
| out_right | output | 16 | Right output sample, signed |
| automute_active | output | 1 | Outputs forced to zero by a long zero run |

## Verification
The assertions check the following on every cycle:
- the run count never exceeds its limit, and it stays frozen on idle cycles;
- a nonzero pair clears the run and drops the automute flag on the next edge;
- a disarmed detector never reports a hit;
- an active automute flag always comes with zero outputs;
- each valid input gives exactly one output pulse.

The bench scenarios cover what per-cycle properties cannot:
- the exact 1023/1024 boundary of the zero run;
- arming automute late, after a long run has already been counted;
- mute through the pin alone;
- the rounding and extreme values of the average.

// File: rtl/router_pkg.sv
package router_pkg;

  // Source selector for one output channel; the encoding is fixed by R3.
  typedef enum logic [1:0] {
    SRC_ZERO  = 2'b00,
    SRC_RIGHT = 2'b01,
    SRC_LEFT  = 2'b10,
    SRC_MIX   = 2'b11
  } src_sel_e;

  localparam int unsigned SEL_BITS  = 2;
  localparam int unsigned NUM_CHANS = 2;
  // Channel index inside route_code: slot 0 = right ([1:0]), slot 1 = left ([3:2]).
  localparam int unsigned CH_RIGHT  = 0;
  localparam int unsigned CH_LEFT   = 1;

endpackage

// File: rtl/channel_select.sv
module channel_select
  import router_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] src_left,
  input  logic [W-1:0] src_right,
  input  src_sel_e     sel,
  output logic [W-1:0] chan_out
);

  // Floor average on a W+1 bit signed sum: no overflow is possible (R5).
  function automatic logic [W-1:0] half_sum(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [W:0] sum;
    sum = $signed({a[W-1], a}) + $signed({b[W-1], b});
    return sum[W:1];
  endfunction

  function automatic logic [W-1:0] route(input src_sel_e s, input logic [W-1:0] l,
                                         input logic [W-1:0] r);
    case (s)
      SRC_RIGHT: return r;
      SRC_LEFT:  return l;
      SRC_MIX:   return half_sum(l, r);
      default:   return '0;
    endcase
  endfunction

  assign chan_out = route(sel, src_left, src_right);

endmodule

// File: rtl/zero_run_detector.sv
module zero_run_detector #(
  parameter int unsigned RUN_LEN = 1024,
  parameter int unsigned CW      = $clog2(RUN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic          smp_zero,
  input  logic          armed,
  output logic [CW-1:0] run_cnt,
  output logic          mute_hit
);

  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

  // Saturating increment on zero, clear on any nonzero pair (R7, R9).
  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c, input logic z);
    if (!z)              return '0;
    else if (c == LIMIT) return LIMIT;
    else                 return c + 1'b1;
  endfunction

  logic [CW-1:0] cnt_next;
  logic          run_full;

  assign cnt_next = next_count(run_cnt, smp_zero);
  assign run_full = (cnt_next == LIMIT);
  // Counting goes on while disarmed; the arm only gates the hit (R8, R10).
  assign mute_hit = smp_vld && armed && run_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_cnt <= '0;
    else if (smp_vld) run_cnt <= cnt_next;
  end

  p_run_capped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= LIMIT);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(run_cnt));

  p_nonzero_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && !smp_zero |=> run_cnt == '0);

  p_disarmed_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !mute_hit);

endmodule

// File: rtl/stereo_router_automute.sv
module stereo_router_automute
  import router_pkg::*;
#(
  parameter int unsigned W       = 16,
  parameter int unsigned RUN_LEN = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  input  logic [3:0]   route_code,
  input  logic         zdet_en,
  input  logic         mute_pin,
  output logic         out_vld,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right,
  output logic         automute_active
);

  localparam int unsigned CW = $clog2(RUN_LEN + 1);

  logic [W-1:0]  chan_mux [NUM_CHANS];
  logic [CW-1:0] run_cnt;
  logic          pair_zero;
  logic          armed;
  logic          mute_hit;

  assign pair_zero = (in_left == '0) && (in_right == '0);
  assign armed     = zdet_en | mute_pin;

  // One selector per output channel; each takes its own 2-bit field (R3).
  for (genvar ch = 0; ch < NUM_CHANS; ch++) begin : g_chan
    channel_select #(.W(W)) u_sel (
      .src_left  (in_left),
      .src_right (in_right),
      .sel       (src_sel_e'(route_code[ch*SEL_BITS +: SEL_BITS])),
      .chan_out  (chan_mux[ch])
    );
  end

  zero_run_detector #(.RUN_LEN(RUN_LEN), .CW(CW)) u_zdet (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (in_vld),
    .smp_zero (pair_zero),
    .armed    (armed),
    .run_cnt  (run_cnt),
    .mute_hit (mute_hit)
  );

  // Output stage: one register between a valid pair and its result (R2).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld         <= 1'b0;
      out_left        <= '0;
      out_right       <= '0;
      automute_active <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        automute_active <= mute_hit;
        out_left        <= mute_hit ? '0 : chan_mux[CH_LEFT];
        out_right       <= mute_hit ? '0 : chan_mux[CH_RIGHT];
      end
    end
  end

  p_mute_forces_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    automute_active |-> (out_left == '0) && (out_right == '0));

  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld && $stable(out_left) && $stable(out_right));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && !pair_zero |=> !automute_active);

  p_disarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld && !armed |=> !automute_active);

endmodule

// File: tb/test_stereo_router_automute.sv
module test_stereo_router_automute;

  localparam int W = 16;
  localparam int RUN = 1024;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic [W-1:0] in_left = '0;
  logic [W-1:0] in_right = '0;
  logic [3:0]   route_code = 4'b1001;
  logic         zdet_en = 1'b0;
  logic         mute_pin = 1'b0;
  logic         out_vld;
  logic [W-1:0] out_left;
  logic [W-1:0] out_right;
  logic         automute_active;

  int n_checks = 0;
  int n_fail = 0;
  int ref_run = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  stereo_router_automute #(.W(W), .RUN_LEN(RUN)) i_stereo_router_automute (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_left(in_left), .in_right(in_right),
    .route_code(route_code), .zdet_en(zdet_en), .mute_pin(mute_pin), .out_vld(out_vld),
    .out_left(out_left), .out_right(out_right), .automute_active(automute_active)
  );

  function automatic int halve(int s);
    if (s < 0 && (s % 2) != 0) return (s - 1) / 2;
    return s / 2;
  endfunction

  function automatic int pick(logic [1:0] f, int l, int r);
    if (f == 2'd1) return r;
    if (f == 2'd2) return l;
    if (f == 2'd3) return halve(l + r);
    return 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Send one pair, then check the registered result one edge later.
  task automatic send(int l, int r);
    bit muted;
    string req;
    int el, er;
    if (l == 0 && r == 0) ref_run = (ref_run < RUN) ? ref_run + 1 : RUN;
    else ref_run = 0;
    muted = (zdet_en || mute_pin) && (ref_run == RUN);
    el = muted ? 0 : pick(route_code[3:2], l, r);
    er = muted ? 0 : pick(route_code[1:0], l, r);
    if (muted) req = "R6";
    else if (route_code inside {4'b0000, 4'b1001, 4'b0110, 4'b1111}) req = "R4";
    else req = "R3";
    in_left = W'(l);
    in_right = W'(r);
    in_vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_vld = 1'b0;
    check("R2", "out_vld", int'(out_vld), 1);
    check(req, "out_left", int'($signed(out_left)), el);
    check(req, "out_right", int'($signed(out_right)), er);
    check(muted ? "R6" : "R7", "automute_active", int'(automute_active), int'(muted));
  endtask

  task automatic zeros(int n);
    for (int i = 0; i < n; i++) send(0, 0);
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "out_vld", int'(out_vld), 0);
    check("R1", "out_left", int'(out_left), 0);
    check("R1", "out_right", int'(out_right), 0);
    check("R1", "automute_active", int'(automute_active), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: named codes
    route_code = 4'b1001; send(100, -200);
    route_code = 4'b0110; send(100, -200);
    route_code = 4'b1111; send(100, -201);
    route_code = 4'b0000; send(1234, 5678);
    // R3: mixed fields
    route_code = 4'b1100; send(7, 9);
    route_code = 4'b0011; send(-7, 8);
    route_code = 4'b0101; send(3, -4);
    // R5: average extremes and rounding
    route_code = 4'b1111;
    send(32767, 32767);
    send(-32768, -32768);
    send(-1, 0);
    send(32767, -32768);

    // R2: idle cycles leave outputs alone
    route_code = 4'b1001; send(11, 22);
    repeat (3) @(negedge clk);
    check("R2", "out_vld idle", int'(out_vld), 0);
    check("R2", "out_left held", int'($signed(out_left)), 11);

    // R8: disarmed long run never mutes
    zdet_en = 1'b0; mute_pin = 1'b0;
    zeros(1100);
    check("R8", "disarmed run", int'(automute_active), 0);
    // R10: arming after a counted run mutes on the next zero
    zdet_en = 1'b1;
    send(0, 0);
    check("R10", "late arm", int'(automute_active), 1);
    // R7: nonzero releases at once
    send(0, 5);
    check("R7", "release", int'(automute_active), 0);

    // R6/R8: pin alone arms; boundary 1023/1024
    zdet_en = 1'b0; mute_pin = 1'b1;
    zeros(RUN - 1);
    check("R6", "1023rd zero", int'(automute_active), 0);
    send(0, 0);
    check("R6", "1024th zero", int'(automute_active), 1);
    // R9: idle gaps and longer runs stay muted
    repeat (5) @(negedge clk);
    zeros(20);
    check("R9", "saturated run", int'(automute_active), 1);
    send(-3, 0);
    check("R7", "release left", int'(automute_active), 0);

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      int l, r;
      route_code = 4'($urandom);
      zdet_en = 1'($urandom);
      mute_pin = 1'($urandom);
      l = ($urandom % 4 == 0) ? 0 : int'($signed(W'($urandom)));
      r = ($urandom % 4 == 0) ? 0 : int'($signed(W'($urandom)));
      send(l, r);
      if ($urandom % 8 == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule